// File: doc/BRIEF.md
# Mesh Tile 8-bit Processing Element

This block is one processing element of a two-dimensional tiled array. It runs its own program from a private 256-word store of 20-bit instructions. Each instruction is fetched in one cycle and decoded and executed in the next, so one instruction retires per clock. It works on a sixteen-entry bank of 8-bit registers. Four of those registers are exported to the north, south, east and west neighbours. The element can read the sixteen registers that its four neighbours export to it. An input register is written from outside and cannot be written by the program. An output register drives the actuator port.

A separate event/idle unit sits beside the element and drives `stall_i`. While `stall_i` is high, the element freezes: it keeps its program counter, pipeline, registers and flags. The event unit also supplies an 8-bit event vector, which a program can use as an operand. The program store has a single port. It is filled through that port while the element is held in reset.

The sequencer has three named states. `ST_BOOT` is the first fetch after reset, with nothing yet to execute. `ST_RUN` executes the held instruction while fetching the next one. `ST_FLUSH` discards the word fetched behind a taken jump while fetching the jump target. The transitions are:
- BOOT_TO_RUN: `ST_BOOT` goes to `ST_RUN` on the first unstalled cycle.
- RUN_TO_FLUSH: `ST_RUN` goes to `ST_FLUSH` on a taken jump.
- FLUSH_TO_RUN: `ST_FLUSH` goes to `ST_RUN` on the next unstalled cycle.
- RUN_HOLD: `ST_RUN` stays in `ST_RUN` otherwise.
- Every state holds while `stall_i` is high.

Top module: `mesh_pe_core`

## Requirements
- R1: Reset (asynchronous, `rst_n` low) has the following effects.
  - It clears all sixteen registers, both flags and the program counter.
  - `actuator_o` and `comm_o` read 0.
  - The first instruction executed after release is the one at address 0.
- R2: Sequential instructions retire one per clock. The result of an instruction appears two clock edges after it is fetched, and consecutive results appear on consecutive edges.
- R3: The instruction word has five fields. Bits 19:16 are the opcode. Bits 15:14 are the operand-A source. Bits 13:10 are the destination register. Bits 9:6 are the operand-B register. Bits 5:0 are the low field.
- R4: Operand A is chosen by the source bits (values 0 to 3).
  - Source 0 reads local register low[3:0].
  - Source 1 reads a neighbour register. low[3:2] picks the neighbour (0 north, 1 south, 2 east, 3 west). low[1:0] picks byte k, which is bits 8k+7:8k of that neighbour's bus.
  - Source 2 is the immediate {B[1:0], low[5:0]}. For this source, operand B is the destination register.
  - Source 3 is the event vector.
  - For sources 0, 1 and 3, operand B is register B.
- R5: ADD (opcode 0) writes the 8-bit sum A+B+C. C takes the carry out. Z is set when the result is 0.
- R6: SHL (1) writes A shifted left by one and sets C to A[7]. SHR (2) writes A shifted right by one and sets C to A[0]. Both set Z from the result.
- R7: The logic operations write their result, update Z and leave C unchanged.
  - AND (4) writes A&B.
  - OR (5) writes A|B.
  - XOR (6) writes A^B.
  - NOT (7) writes ~A.
- R8: CMP (3) computes B-A for the flags only. Z is set when A equals B. C is set when B is less than A. No register is written.
- R9: The jump opcodes load the target {B[1:0], low[5:0]} into the program counter. JMP (8) always jumps. JC (9) jumps when C=1. JZ (10) jumps when Z=1. JNC (11) jumps when C=0. JNZ (12) jumps when Z=0. The word after a taken jump is never executed. A jump that is not taken falls through.
- R10: While `stall_i` is high, the program counter, pipeline, flags and every program-written register hold their values.
- R11: Register 14 is the input register. It loads `sensor_d_i` when `sensor_we_i` is high, and program writes to it are ignored.
- R12: Register 15 drives `actuator_o`. Registers 12, 11, 10 and 9 drive `comm_o`, from its top byte down to its bottom byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze request from the event/idle unit |
| evt_vec_i | input | 8 | Event vector operand |
| nbr_n_i | input | 32 | Four registers exported by the north neighbour |
| nbr_s_i | input | 32 | Four registers exported by the south neighbour |
| nbr_e_i | input | 32 | Four registers exported by the east neighbour |
| nbr_w_i | input | 32 | Four registers exported by the west neighbour |
| sensor_we_i | input | 1 | Write strobe of the input register |
| sensor_d_i | input | 8 | Input register data |
| imem_we_i | input | 1 | Program store write strobe (used while in reset) |
| imem_addr_i | input | 8 | Program store write address |
| imem_wdata_i | input | 20 | Program store write data |
| comm_o | output | 32 | Registers 12..9 exported to all four neighbours |
| actuator_o | output | 8 | Contents of register 15 |

## Verification
Several properties are checked by assertions on every cycle:
- the program counter steps by one or lands on the decoded jump target;
- a stall freezes the counter and the visible registers;
- a flush cycle changes no output;
- CMP never requests a write-back;
- the input register changes only on its strobe.

Other behaviour is shown only by the bench's programs:
- the arithmetic values and carry chaining;
- operand selection across neighbours, the immediate and the event vector;
- whether a conditional jump is taken from the flags;
- the squashing of the word behind a jump;
- the result cadence of one instruction per clock.

// File: rtl/pe_pkg.sv
package pe_pkg;
    localparam int DATA_W    = 8;
    localparam int INSTR_W   = 20;
    localparam int NREG      = 16;
    localparam int REG_IDX_W = $clog2(NREG);
    localparam int NCOMM     = 4;
    localparam int NDIR      = 4;
    localparam int COMM_BASE = 9;
    localparam int SENSOR_IX = 14;
    localparam int ACT_IX    = 15;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_SHL = 4'd1, OP_SHR = 4'd2, OP_CMP = 4'd3,
        OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_NOT = 4'd7,
        OP_JMP = 4'd8, OP_JC  = 4'd9, OP_JZ  = 4'd10, OP_JNC = 4'd11,
        OP_JNZ = 4'd12, OP_R13 = 4'd13, OP_R14 = 4'd14, OP_R15 = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0, SRC_NBR = 2'd1, SRC_IMM = 2'd2, SRC_EVT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0, ST_RUN = 2'd1, ST_FLUSH = 2'd2
    } seq_state_e;

    typedef struct packed {
        opcode_e                op;
        src_e                   src;
        logic [REG_IDX_W-1:0]   dst;
        logic [REG_IDX_W-1:0]   rb;
        logic [5:0]             low;
    } instr_t;
endpackage

// File: rtl/pe_imem.sv
module pe_imem #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 20,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) store_q[addr_i] <= wdata_i;
            else      rdata_o         <= store_q[addr_i];
        end
    end
endmodule

// File: rtl/pe_regfile.sv
module pe_regfile
    import pe_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we_i,
    input  logic [REG_IDX_W-1:0]      waddr_i,
    input  logic [DATA_W-1:0]         wdata_i,
    input  logic                      sens_we_i,
    input  logic [DATA_W-1:0]         sens_d_i,
    input  logic [REG_IDX_W-1:0]      ra_i,
    input  logic [REG_IDX_W-1:0]      rb_i,
    output logic [DATA_W-1:0]         ra_o,
    output logic [DATA_W-1:0]         rb_o,
    output logic [NCOMM*DATA_W-1:0]   comm_o,
    output logic [DATA_W-1:0]         act_o
);
    logic [DATA_W-1:0] bank_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == SENSOR_IX) begin : g_sensor
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         bank_q[g] <= '0;
                else if (sens_we_i) bank_q[g] <= sens_d_i;
            end
        end else begin : g_prog
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                     bank_q[g] <= '0;
                else if (we_i && waddr_i == REG_IDX_W'(g))      bank_q[g] <= wdata_i;
            end
        end
    end

    for (genvar c = 0; c < NCOMM; c++) begin : g_comm
        assign comm_o[c*DATA_W +: DATA_W] = bank_q[COMM_BASE + c];
    end

    assign ra_o  = bank_q[ra_i];
    assign rb_o  = bank_q[rb_i];
    assign act_o = bank_q[ACT_IX];

    AST_SENSOR_RO: assert property (@(posedge clk) disable iff (!rst_n)
        !sens_we_i |=> $stable(bank_q[SENSOR_IX])) else $error("sensor reg changed"); // R11
endmodule

// File: rtl/pe_alu.sv
module pe_alu
    import pe_pkg::*;
(
    input  opcode_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              z_o,
    output logic              wr_o
);
    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   diff_w;

    always_comb begin
        sum_w  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, c_i};
        diff_w = {1'b0, b_i} - {1'b0, a_i};
        res_o  = '0;
        c_o    = c_i;
        wr_o   = 1'b1;
        unique case (op_i)
            OP_ADD: begin res_o = sum_w[DATA_W-1:0]; c_o = sum_w[DATA_W]; end
            OP_SHL: begin res_o = a_i << 1; c_o = a_i[DATA_W-1]; end
            OP_SHR: begin res_o = a_i >> 1; c_o = a_i[0]; end
            OP_CMP: begin res_o = diff_w[DATA_W-1:0]; c_o = diff_w[DATA_W]; wr_o = 1'b0; end
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_NOT: res_o = ~a_i;
            default: wr_o = 1'b0;
        endcase
        z_o = (res_o == '0);
    end

    always_comb begin
        if (op_i == OP_CMP) begin
            AST_CMP_NO_WB: assert (!wr_o) else $error("cmp writes back"); // R8
        end
    end
endmodule

// File: rtl/mesh_pe_core.sv
module mesh_pe_core
    import pe_pkg::*;
#(
    parameter int IMEM_DEPTH = 256,
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stall_i,
    input  logic [7:0]              evt_vec_i,
    input  logic [31:0]             nbr_n_i,
    input  logic [31:0]             nbr_s_i,
    input  logic [31:0]             nbr_e_i,
    input  logic [31:0]             nbr_w_i,
    input  logic                    sensor_we_i,
    input  logic [7:0]              sensor_d_i,
    input  logic                    imem_we_i,
    input  logic [PC_W-1:0]         imem_addr_i,
    input  logic [19:0]             imem_wdata_i,
    output logic [31:0]             comm_o,
    output logic [7:0]              actuator_o
);
    localparam int NBR_W = NDIR * NCOMM * DATA_W;

    seq_state_e        state_q, state_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic              flag_c_q, flag_z_q;
    logic              exec;
    logic              fetch_en;
    logic [INSTR_W-1:0] rdata;
    instr_t            ins;
    logic [7:0]        jmp_tgt8;
    logic [PC_W-1:0]   jmp_tgt;
    logic              jump_taken;
    logic              is_alu;
    logic [DATA_W-1:0] ra_val, rb_val, opa;
    logic [REG_IDX_W-1:0] rb_sel;
    logic [NBR_W-1:0]  nbr_all;
    logic [DATA_W-1:0] alu_res;
    logic              alu_c, alu_z, alu_wr;
    logic              rf_we;

    assign fetch_en = imem_we_i || (rst_n && !stall_i);

    pe_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) imem_i (
        .clk     (clk),
        .en_i    (fetch_en),
        .we_i    (imem_we_i),
        .addr_i  (imem_we_i ? imem_addr_i : pc_q),
        .wdata_i (imem_wdata_i),
        .rdata_o (rdata)
    );

    assign ins      = instr_t'(rdata);
    assign jmp_tgt8 = {ins.rb[1:0], ins.low};
    assign jmp_tgt  = jmp_tgt8[PC_W-1:0];
    assign is_alu   = !ins.op[3];

    always_comb begin
        unique case (ins.op)
            OP_JMP:  jump_taken = 1'b1;
            OP_JC:   jump_taken = flag_c_q;
            OP_JZ:   jump_taken = flag_z_q;
            OP_JNC:  jump_taken = !flag_c_q;
            OP_JNZ:  jump_taken = !flag_z_q;
            default: jump_taken = 1'b0;
        endcase
    end

    // Sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Sequencer: next state and outputs
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        exec    = 1'b0;
        if (!stall_i) begin
            unique case (state_q)
                ST_BOOT: begin
                    pc_d    = pc_q + 1'b1;
                    state_d = ST_RUN;
                end
                ST_RUN: begin
                    exec = 1'b1;
                    if (jump_taken) begin
                        pc_d    = jmp_tgt;
                        state_d = ST_FLUSH;
                    end else begin
                        pc_d = pc_q + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    pc_d    = pc_q + 1'b1;
                    state_d = ST_RUN;
                end
                default: state_d = ST_BOOT;
            endcase
        end
    end

    assign nbr_all = {nbr_w_i, nbr_e_i, nbr_s_i, nbr_n_i};
    assign rb_sel  = (ins.src == SRC_IMM) ? ins.dst : ins.rb;

    always_comb begin
        unique case (ins.src)
            SRC_REG: opa = ra_val;
            SRC_NBR: opa = nbr_all[{ins.low[3:0], 3'b000} +: DATA_W];
            SRC_IMM: opa = jmp_tgt8;
            SRC_EVT: opa = evt_vec_i;
            default: opa = '0;
        endcase
    end

    pe_alu alu_i (
        .op_i  (ins.op),
        .a_i   (opa),
        .b_i   (rb_val),
        .c_i   (flag_c_q),
        .res_o (alu_res),
        .c_o   (alu_c),
        .z_o   (alu_z),
        .wr_o  (alu_wr)
    );

    assign rf_we = exec && is_alu && alu_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_c_q <= 1'b0;
            flag_z_q <= 1'b0;
        end else if (exec && is_alu) begin
            flag_c_q <= alu_c;
            flag_z_q <= alu_z;
        end
    end

    pe_regfile rf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (rf_we),
        .waddr_i   (ins.dst),
        .wdata_i   (alu_res),
        .sens_we_i (sensor_we_i),
        .sens_d_i  (sensor_d_i),
        .ra_i      (ins.low[3:0]),
        .rb_i      (rb_sel),
        .ra_o      (ra_val),
        .rb_o      (rb_val),
        .comm_o    (comm_o),
        .act_o     (actuator_o)
    );

    AST_STALL_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_q)) else $error("pc moved in stall"); // R10
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(actuator_o) && $stable(comm_o) && $stable(flag_c_q) && $stable(flag_z_q))) else $error("write in stall"); // R10
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stall_i && !jump_taken) |=> (pc_q == $past(pc_q) + 1'b1)) else $error("pc step"); // R2
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !stall_i && jump_taken) |=> (pc_q == $past(jmp_tgt))) else $error("jump target"); // R9
    AST_FLUSH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> ($stable(actuator_o) && $stable(comm_o))) else $error("flush wrote"); // R9
endmodule

// File: tb/mesh_pe_core_tb_top.sv
`timescale 1ns/1ps
module mesh_pe_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [7:0]  evt_vec_i = '0;
    logic [31:0] nbr_n_i = '0, nbr_s_i = '0, nbr_e_i = '0, nbr_w_i = '0;
    logic        sensor_we_i = 1'b0;
    logic [7:0]  sensor_d_i = '0;
    logic        imem_we_i = 1'b0;
    logic [7:0]  imem_addr_i = '0;
    logic [19:0] imem_wdata_i = '0;
    logic [31:0] comm_o;
    logic [7:0]  actuator_o;

    int n_run = 0;
    int n_fail = 0;
    logic [19:0] prog [16];
    int prog_len = 0;

    always #2 clk = ~clk;

    mesh_pe_core dut_i (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .evt_vec_i(evt_vec_i),
        .nbr_n_i(nbr_n_i), .nbr_s_i(nbr_s_i), .nbr_e_i(nbr_e_i), .nbr_w_i(nbr_w_i),
        .sensor_we_i(sensor_we_i), .sensor_d_i(sensor_d_i),
        .imem_we_i(imem_we_i), .imem_addr_i(imem_addr_i), .imem_wdata_i(imem_wdata_i),
        .comm_o(comm_o), .actuator_o(actuator_o)
    );

    function automatic logic [19:0] enc(input logic [3:0] op, input logic [1:0] src,
                                         input logic [3:0] dst, input logic [3:0] rb,
                                         input logic [7:0] v);
        logic [1:0] rb_lo;
        rb_lo = (src == 2'd2 || op[3]) ? v[7:6] : rb[1:0];
        return {op, src, dst, rb[3:2], rb_lo, v[5:0]};
    endfunction
    function automatic logic [19:0] ld(input logic [3:0] d, input logic [7:0] val);
        return enc(4'd7, 2'd2, d, 4'd0, ~val);
    endfunction
    function automatic logic [19:0] mov(input logic [3:0] d, input logic [3:0] s);
        return enc(4'd5, 2'd0, d, 4'd0, {4'd0, s});
    endfunction
    function automatic logic [19:0] jop(input logic [3:0] op, input logic [7:0] t);
        return enc(op, 2'd0, 4'd0, 4'd0, t);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Load prog[0:prog_len-1] under reset, then release reset.
    task automatic boot();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < prog_len; i++) begin
            imem_we_i = 1'b1; imem_addr_i = 8'(i); imem_wdata_i = prog[i];
            @(negedge clk);
        end
        imem_we_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    // {op, a, b, expected}
    localparam logic [27:0] VEC [8] = '{
        {4'd0, 8'd200, 8'd100, 8'd44},
        {4'd0, 8'h12,  8'h34,  8'h46},
        {4'd1, 8'h81,  8'h00,  8'h02},
        {4'd2, 8'h81,  8'h00,  8'h40},
        {4'd4, 8'hF0,  8'h3C,  8'h30},
        {4'd5, 8'hF0,  8'h0F,  8'hFF},
        {4'd6, 8'hFF,  8'h0F,  8'hF0},
        {4'd7, 8'h0F,  8'h55,  8'hF0}
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [27:0] v;
        int waitc;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset actuator", {24'd0, actuator_o}, 32'd0);
        chk("R1 reset comm", comm_o, 32'd0);

        // Vector table: R5 R6 R7 (R3 encoding used throughout)
        for (int k = 0; k < 8; k++) begin
            v = VEC[k];
            prog[0] = ld(4'd1, v[15:8]);
            prog[1] = enc(v[27:24], 2'd2, 4'd1, 4'd0, v[23:16]);
            prog[2] = mov(4'd15, 4'd1);
            prog[3] = jop(4'd8, 8'd3);
            prog_len = 4;
            boot();
            settle();
            chk($sformatf("R5/R6/R7 vector %0d", k), {24'd0, actuator_o}, {24'd0, v[7:0]});
        end

        // R5 carry chaining and R12 comm export
        prog[0] = ld(4'd1, 8'd200);
        prog[1] = enc(4'd0, 2'd2, 4'd1, 4'd0, 8'd100);
        prog[2] = enc(4'd0, 2'd2, 4'd2, 4'd0, 8'd0);
        prog[3] = mov(4'd15, 4'd2);
        prog[4] = mov(4'd9, 4'd1);
        prog[5] = jop(4'd8, 8'd5);
        prog_len = 6;
        boot(); settle();
        chk("R5 carry in", {24'd0, actuator_o}, 32'd1);
        chk("R12 comm low byte", {24'd0, comm_o[7:0]}, 32'd44);

        // R4 neighbour and event sources
        nbr_s_i = 32'hDDCCBBAA; nbr_w_i = 32'h44332211; nbr_n_i = 32'h0F0E0D0C;
        evt_vec_i = 8'h25;
        prog[0] = enc(4'd5, 2'd1, 4'd15, 4'd0, 8'b0000_0110);
        prog[1] = enc(4'd5, 2'd1, 4'd10, 4'd0, 8'b0000_1111);
        prog[2] = enc(4'd5, 2'd3, 4'd11, 4'd0, 8'd0);
        prog[3] = enc(4'd5, 2'd1, 4'd12, 4'd0, 8'b0000_0001);
        prog[4] = jop(4'd8, 8'd4);
        prog_len = 5;
        boot(); settle();
        chk("R4 south byte 2", {24'd0, actuator_o}, 32'hCC);
        chk("R4 west/event/north into comm", comm_o, 32'h0D254400);

        // R8 R9 compare and conditional jumps
        prog[0]  = ld(4'd1, 8'd5);
        prog[1]  = enc(4'd3, 2'd2, 4'd1, 4'd0, 8'd5);
        prog[2]  = jop(4'd10, 8'd4);
        prog[3]  = ld(4'd15, 8'hBB);
        prog[4]  = enc(4'd3, 2'd2, 4'd1, 4'd0, 8'd9);
        prog[5]  = jop(4'd9, 8'd7);
        prog[6]  = ld(4'd15, 8'hBB);
        prog[7]  = jop(4'd12, 8'd9);
        prog[8]  = ld(4'd15, 8'hBB);
        prog[9]  = jop(4'd11, 8'd12);
        prog[10] = mov(4'd15, 4'd1);
        prog[11] = jop(4'd8, 8'd11);
        prog[12] = ld(4'd15, 8'hEE);
        prog[13] = jop(4'd8, 8'd13);
        prog_len = 14;
        boot(); settle();
        chk("R8 R9 cmp flags, no write-back, jump paths", {24'd0, actuator_o}, 32'd5);

        // R9 squash behind a taken jump
        prog[0] = jop(4'd8, 8'd2);
        prog[1] = ld(4'd2, 8'h11);
        prog[2] = mov(4'd15, 4'd2);
        prog[3] = jop(4'd8, 8'd3);
        prog_len = 4;
        boot(); settle();
        chk("R9 squashed slot", {24'd0, actuator_o}, 32'd0);

        // R11 sensor register, R12 comm
        prog[0] = ld(4'd14, 8'h33);
        prog[1] = mov(4'd15, 4'd14);
        prog[2] = ld(4'd9, 8'h11);
        prog[3] = ld(4'd10, 8'h22);
        prog[4] = ld(4'd11, 8'h33);
        prog[5] = ld(4'd12, 8'h44);
        prog[6] = jop(4'd8, 8'd6);
        prog_len = 7;
        boot();
        sensor_we_i = 1'b1; sensor_d_i = 8'h5A;
        @(negedge clk);
        sensor_we_i = 1'b0;
        settle();
        chk("R11 sensor read-only", {24'd0, actuator_o}, 32'h5A);
        chk("R12 comm order", comm_o, 32'h44332211);

        // R1 R2 R10 cadence and stall
        prog[0] = ld(4'd15, 8'd1);
        prog[1] = ld(4'd15, 8'd2);
        prog[2] = ld(4'd15, 8'd3);
        prog[3] = ld(4'd15, 8'd4);
        prog[4] = jop(4'd8, 8'd4);
        prog_len = 5;
        boot();
        chk("R1 first slot from address 0", {24'd0, actuator_o}, 32'd0);
        waitc = 0;
        while (actuator_o != 8'd1 && waitc < 10) begin
            @(negedge clk); waitc++;
        end
        chk("R1 R2 first result latency", waitc, 2);
        @(negedge clk);
        chk("R2 next result next cycle", {24'd0, actuator_o}, 32'd2);
        stall_i = 1'b1;
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            chk("R10 hold in stall", {24'd0, actuator_o}, 32'd2);
        end
        stall_i = 1'b0;
        @(negedge clk);
        chk("R10 resume after stall", {24'd0, actuator_o}, 32'd3);
        @(negedge clk);
        chk("R2 continues", {24'd0, actuator_o}, 32'd4);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule